// File: doc/BRIEF.md
# Two-Stage Pipelined Multiply-Accumulate

This block multiplies two signed operands on every clock and folds each product into a running signed total. The work is split over two register stages so that the multiplier and the adder never sit in the same combinational path. The first stage forms the product and holds it in a pipeline register. The second stage adds that held product to the accumulator.

Viewed from the ports, the block gives the same stream of totals as a one-cycle multiply-accumulate, one cycle later. Its first output after reset is therefore an extra zero. Operands and totals are two's-complement and wrap at the accumulator width. A synchronous reset clears both registers.

Top module: `mac_pipe`

## Requirements
- R1: While `rst` is high at a rising clock edge, the product register and the accumulator are both cleared, so `accOut` reads 0 after that edge, whatever the operands are.
- R2: After the last reset edge, the value on `accOut` following the first edge with `rst` low is 0. This is the leading zero.
- R3: On each edge with `rst` low, `accOut` becomes its previous value plus the stored product.
- R4: The product of the operands presented at one edge reaches `accOut` exactly one edge later than a one-cycle accumulator would show it. A single nonzero operand pair followed by zeros changes `accOut` once, two edges after it is presented.
- R5: For any operand stream, the sequence on `accOut` equals the sequence of a one-cycle reference (total ← total + opA·opB) delayed by one cycle, with 0 as its first value. For example, reference totals 3, 5, 1, 2, 4, −1, 0 appear on `accOut` as 0, 3, 5, 1, 2, 4, −1, 0.
- R6: The accumulator is 16-bit two's-complement and wraps on overflow. Adding 16384 twice to 0 gives −32768.
- R7: Operands are 8-bit signed. Products and totals keep their sign: −128·127 gives −16256 and −128·−128 gives +16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of both stages |
| opA | input | 8 | First signed operand, sampled every edge |
| opB | input | 8 | Second signed operand, sampled every edge |
| accOut | output | 16 | Signed accumulator value |

## Verification
A wrong value held in the product register shows at the ports one edge after it is captured, as a wrong step in `accOut`. From then on the error persists in every later total, because the accumulator never forgets. A wrong accumulator shows at once on `accOut`. A stage skipped or doubled moves the output stream by a cycle against the delayed reference, so the first nonzero product after reset lands on the wrong edge. The sweep over every operand pair compares each cycle against that reference, so any such fault is caught within a few cycles of the first affected pair.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef struct packed {
    logic clearProd;
    logic loadProd;
    logic clearAcc;
    logic loadAcc;
  } macStrobes_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        rst,
  output macStrobes_t strb
);

  // Both stages advance on every edge; reset overrides each of them.
  always_comb begin
    strb.clearProd = rst;
    strb.clearAcc  = rst;
    strb.loadProd  = !rst;
    strb.loadAcc   = !rst;
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic                     clk,
  input  macStrobes_t              strb,
  input  logic signed [OP_W-1:0]   opA,
  input  logic signed [OP_W-1:0]   opB,
  output logic signed [2*OP_W-1:0] prodQ,
  output logic signed [ACC_W-1:0]  accQ
);

  localparam int PROD_W = 2 * OP_W;

  logic signed [PROD_W-1:0] prodNext;
  logic signed [ACC_W-1:0]  prodWide;
  logic signed [ACC_W-1:0]  accNext;

  // Stage one: multiply only.
  assign prodNext = opA * opB;

  always_ff @(posedge clk) begin
    if (strb.clearProd) prodQ <= '0;
    else if (strb.loadProd) prodQ <= prodNext;
  end

  // Fit the held product to the accumulator width.
  generate
    if (ACC_W > PROD_W) begin : g_extend
      assign prodWide = {{(ACC_W - PROD_W){prodQ[PROD_W-1]}}, prodQ};
    end else begin : g_fit
      assign prodWide = prodQ[ACC_W-1:0];
    end
  endgenerate

  // Stage two: add only.
  assign accNext = accQ + prodWide;

  always_ff @(posedge clk) begin
    if (strb.clearAcc) accQ <= '0;
    else if (strb.loadAcc) accQ <= accNext;
  end

endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import mac_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [OP_W-1:0]  opA,
  input  logic signed [OP_W-1:0]  opB,
  output logic signed [ACC_W-1:0] accOut
);

  macStrobes_t               strb;
  logic signed [2*OP_W-1:0]  prodQ;

  mac_ctrl u_ctrl (
    .rst  (rst),
    .strb (strb)
  );

  mac_datapath #(
    .OP_W  (OP_W),
    .ACC_W (ACC_W)
  ) u_dp (
    .clk   (clk),
    .strb  (strb),
    .opA   (opA),
    .opB   (opB),
    .prodQ (prodQ),
    .accQ  (accOut)
  );

endmodule

// File: rtl/mac_pipe_chk.sv
module mac_pipe_chk #(
  parameter int OP_W  = 8,
  parameter int ACC_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic signed [OP_W-1:0]   opA,
  input logic signed [OP_W-1:0]   opB,
  input logic signed [ACC_W-1:0]  accOut,
  input logic signed [2*OP_W-1:0] prodQ
);

  localparam int PROD_W = 2 * OP_W;

  logic       armed = 1'b0;
  logic [1:0] runLen = 2'd0;
  logic signed [PROD_W-1:0] opProd;

  assign opProd = opA * opB;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b1;
      runLen <= 2'd0;
    end else if (runLen != 2'd3) begin
      runLen <= runLen + 2'd1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (accOut == '0 && prodQ == '0));

  // R2
  leading_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && runLen == 2'd0) |=> accOut == '0);

  // R3
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && runLen != 2'd0) |=>
      accOut == ACC_W'($past(accOut) + ACC_W'($signed($past(prodQ)))));

  // R4
  prod_stage_chk: assert property (@(posedge clk) disable iff (rst)
    armed |=> prodQ == $past(opProd));

endmodule

bind mac_pipe mac_pipe_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .opA    (opA),
  .opB    (opB),
  .accOut (accOut),
  .prodQ  (prodQ)
);

// File: tb/mac_pipe_test.sv
`timescale 1ns/1ps
module mac_pipe_test;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [7:0]  opA = '0;
  logic signed [7:0]  opB = '0;
  logic signed [15:0] accOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic signed [15:0] refAcc = '0;
  logic signed [15:0] expOut = '0;

  always #4 clk = ~clk;

  mac_pipe uut (
    .clk    (clk),
    .rst    (rst),
    .opA    (opA),
    .opB    (opB),
    .accOut (accOut)
  );

  task automatic check(input string tag, input logic signed [15:0] got,
                       input logic signed [15:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s accOut=%0d expected %0d", tag, got, want);
    end
  endtask

  // Drive one cycle at a falling edge, update the model, check at the next.
  task automatic cycle(input int a, input int b, input bit r, input string tag);
    opA = 8'(a);
    opB = 8'(b);
    rst = r;
    if (r) begin
      expOut = '0;
      refAcc = '0;
    end else begin
      expOut = refAcc;
      refAcc = 16'(int'(refAcc) + a * b);
    end
    @(negedge clk);
    check(tag, accOut, expOut);
  endtask

  initial begin
    int seqA[8] = '{3, 2, -4, 1, 2, -5, 1, 0};
    int seqOut[8] = '{0, 3, 5, 1, 2, 4, -1, 0};
    @(negedge clk);

    // R1: reset with nonzero operands
    cycle(77, -3, 1, "R1");
    cycle(-128, -128, 1, "R1");
    check("R1", accOut, 16'sd0);

    // R2 / R5: directed stream with a leading zero
    for (int i = 0; i < 8; i++) begin
      cycle(seqA[i], (i == 7) ? 0 : 1, 0, (i == 0) ? "R2" : "R5");
      check((i == 0) ? "R2" : "R5", accOut, 16'(seqOut[i]));
    end

    // R1: reset in the middle of accumulation
    cycle(9, 9, 0, "R3");
    cycle(9, 9, 0, "R3");
    cycle(50, 50, 1, "R1");
    check("R1", accOut, 16'sd0);

    // R4: single pulse lands two edges after it is presented
    cycle(5, -7, 0, "R4");
    check("R4", accOut, 16'sd0);
    cycle(0, 0, 0, "R4");
    check("R4", accOut, -16'sd35);
    cycle(0, 0, 0, "R4");
    check("R4", accOut, -16'sd35);

    // R7: signed products
    cycle(0, 0, 1, "R1");
    cycle(-128, 127, 0, "R7");
    cycle(0, 0, 0, "R7");
    check("R7", accOut, -16'sd16256);
    cycle(0, 0, 1, "R1");
    cycle(-128, -128, 0, "R7");
    cycle(-128, -128, 0, "R7");
    check("R7", accOut, 16'sd16384);

    // R6: wrap at 16 bits
    cycle(0, 0, 0, "R6");
    check("R6", accOut, -16'sd32768);

    // R3 / R5: every operand pair, against the delayed reference
    cycle(0, 0, 1, "R1");
    for (int a = -128; a < 128; a++) begin
      for (int b = -128; b < 128; b++) begin
        cycle(a, b, 0, (b[0]) ? "R3" : "R5");
      end
    end
    cycle(0, 0, 0, "R5");
    cycle(0, 0, 0, "R5");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog accOut=%0d expected completion", accOut);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule